// File: doc/BRIEF.md
# Binary to Three-Modulus Residue Converter

This block converts a signed two's-complement word into its residue-number form over the moduli set {2^N-1, 2^N, 2^N+1}. N is a parameter. The three moduli are pairwise coprime, so their product M is the dynamic range of the residue system. Residue adders and multipliers downstream take each output as one independent channel. With N=3 the moduli are (7, 8, 9), which suits an 8-bit data path. With N=5 they are (31, 32, 33), which suits a 16-bit data path.

Each residue is reduced without a divider or a lookup table. The power-of-two channel takes the low N bits. The 2^N-1 channel sums N-bit chunks of the word with end-around folding. The 2^N+1 channel forms an alternating sum of the chunks and then applies a short compare-and-subtract correction.

A negative input X is treated as M+X, so all three residues stay non-negative. A flag reports inputs that fall outside the signed dynamic range. A word presented with `vld_i` high appears at the outputs one clock later with `vld_o` high. When no word is presented, the outputs keep their last values.

Top module: `rns_fwd_conv`

## Requirements
- R1: `vld_o` is high in the cycle after a cycle in which `vld_i` was high, and low in the cycle after a cycle in which `vld_i` was low.
- R2: After a cycle with `vld_i` low, `res_lo`, `res_pow`, `res_hi` and `oor_o` keep their previous values.
- R3: `res_pow` equals X mod 2^N, which is the low N bits of the input word.
- R4: `res_lo` equals the least non-negative residue of X modulo 2^N-1, in the range 0 to 2^N-2.
- R5: `res_hi` equals the least non-negative residue of X modulo 2^N+1, in the range 0 to 2^N.
- R6: For a negative X, every residue equals the residue of M+X, where M = (2^N-1)·2^N·(2^N+1). For example, X = -1 gives (2^N-2, 2^N-1, 2^N).
- R7: `oor_o` is 1 exactly when X < -M/2 or X > M/2-1. M is always even, so this is the signed range.
- R8: While `rst_n` is low, and in the cycle after reset, `vld_o`, `oor_o` and all three residues are 0.
- R9: An input outside the signed range still produces the exact residues of X on all three channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Input word valid |
| din | input | W | Signed two's-complement input X |
| vld_o | output | 1 | Output residues valid |
| res_lo | output | N | Residue modulo 2^N-1 |
| res_pow | output | N | Residue modulo 2^N |
| res_hi | output | N+1 | Residue modulo 2^N+1 |
| oor_o | output | 1 | X outside the signed dynamic range |

## Verification
Directed values sit around each modulus and its multiples (for example 30 to 34 and 62 to 66). These values separate a missed end-around carry or a missed final correction from a correct reduction. Small negatives, -1 and the most negative word check the sign handling as M+X. The values at -M/2-1, -M/2, M/2-1 and M/2 separate an off-by-one range flag from a correct one. A pseudo-random sweep with gaps in `vld_i` then covers the chunk sums broadly and also tests the hold behaviour and the one-cycle valid timing.

// File: rtl/rns_fwd_pkg.sv
package rns_fwd_pkg;

    // Number of N-bit chunks needed to cover a W-bit word.
    function automatic int chunk_cnt(input int w, input int n);
        return (w + n - 1) / n;
    endfunction

    // Product of the three moduli (2^n-1)*2^n*(2^n+1).
    function automatic longint dyn_range(input int n);
        longint p;
        p = longint'(1) << n;
        return (p - 1) * p * (p + 1);
    endfunction

endpackage

// File: rtl/rns_fold_minus.sv
// Residue modulo 2^N-1 by end-around folding of N-bit chunks.
module rns_fold_minus #(
    parameter int N = 5,
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    output logic [N-1:0] res
);
    import rns_fwd_pkg::*;

    localparam int K  = chunk_cnt(W, N);
    localparam int KW = K * N;
    localparam int SW = N + $clog2(K + 1) + 1;
    localparam logic [N-1:0] ALL1 = {N{1'b1}};

    logic [KW-1:0] ext;
    logic [SW-1:0] acc;
    logic [N-1:0]  folded;
    logic          neg;

    // Sign extension adds neg*2^KW, and 2^KW is 1 modulo 2^N-1.
    assign ext = KW'($signed(din));
    assign neg = din[W-1];

    always_comb begin
        acc = '0;
        for (int k = 0; k < K; k++) begin
            acc = acc + SW'(ext[k*N +: N]);
        end
        for (int f = 0; f < SW; f++) begin
            acc = {{(SW-N){1'b0}}, acc[N-1:0]} + (acc >> N);
        end
        folded = (acc[N-1:0] == ALL1) ? '0 : acc[N-1:0];
        if (neg) begin
            res = (folded == '0) ? (ALL1 - N'(1)) : (folded - N'(1));
        end else begin
            res = folded;
        end
    end
endmodule

// File: rtl/rns_fold_plus.sv
// Residue modulo 2^N+1 by an alternating chunk sum and a final correction.
module rns_fold_plus #(
    parameter int N = 5,
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    output logic [N:0]   res
);
    import rns_fwd_pkg::*;

    localparam int K   = chunk_cnt(W, N);
    localparam int KW  = K * N;
    localparam int MOD = (1 << N) + 1;
    localparam int DW  = N + 2 + $clog2(2 * K + 3);
    localparam int L   = $clog2(2 * K + 2);
    localparam logic [DW-1:0] BIAS = DW'(MOD * (K + 1));

    logic [KW-1:0] ext;
    logic [DW-1:0] pos_sum;
    logic [DW-1:0] neg_sum;
    logic [DW-1:0] d;
    logic          neg;

    // Sign extension adds neg*2^KW, and 2^KW is (-1)^K modulo 2^N+1.
    assign ext = KW'($signed(din));
    assign neg = din[W-1];

    always_comb begin
        pos_sum = '0;
        neg_sum = '0;
        for (int k = 0; k < K; k++) begin
            if (k % 2 == 0) pos_sum = pos_sum + DW'(ext[k*N +: N]);
            else            neg_sum = neg_sum + DW'(ext[k*N +: N]);
        end
        d = pos_sum + BIAS - neg_sum;
        if (neg) begin
            if (K % 2 == 0) d = d - DW'(1);
            else            d = d + DW'(1);
        end
        for (int j = L; j >= 0; j--) begin
            if (d >= (DW'(MOD) << j)) d = d - (DW'(MOD) << j);
        end
        res = d[N:0];
    end
endmodule

// File: rtl/rns_range_flag.sv
// Flags inputs outside the signed dynamic range -M/2 .. M/2-1.
module rns_range_flag #(
    parameter int N = 5,
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    output logic         oor
);
    import rns_fwd_pkg::*;

    localparam longint HALF = dyn_range(N) / 2;

    logic signed [63:0] xs;

    assign xs  = 64'($signed(din));
    assign oor = (xs < -HALF) || (xs > (HALF - 1));
endmodule

// File: rtl/rns_fwd_conv.sv
// Signed binary to {2^N-1, 2^N, 2^N+1} residue converter, one-cycle latency.
module rns_fwd_conv #(
    parameter int N = 5,
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] din,
    output logic         vld_o,
    output logic [N-1:0] res_lo,
    output logic [N-1:0] res_pow,
    output logic [N:0]   res_hi,
    output logic         oor_o
);
    localparam int M_LO = (1 << N) - 1;
    localparam int M_HI = (1 << N) + 1;

    logic [N-1:0] lo_d;
    logic [N:0]   hi_d;
    logic         oor_d;

    rns_fold_minus #(.N(N), .W(W)) u_minus (.din(din), .res(lo_d));
    rns_fold_plus  #(.N(N), .W(W)) u_plus  (.din(din), .res(hi_d));
    rns_range_flag #(.N(N), .W(W)) u_range (.din(din), .oor(oor_d));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o   <= 1'b0;
            res_lo  <= '0;
            res_pow <= '0;
            res_hi  <= '0;
            oor_o   <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                res_lo  <= lo_d;
                res_pow <= din[N-1:0];
                res_hi  <= hi_d;
                oor_o   <= oor_d;
            end
        end
    end

    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);
    // R1
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> !vld_o);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> ($stable(res_lo) && $stable(res_pow) && $stable(res_hi) && $stable(oor_o)));
    // R3
    pow_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (res_pow == $past(din[N-1:0])));
    // R4
    lo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(res_lo) < M_LO);
    // R5
    hi_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(res_hi) < M_HI);
endmodule

// File: tb/sim_rns_fwd_conv.sv
`timescale 1ns/1ps
module sim_rns_fwd_conv;
    localparam int N    = 5;
    localparam int W    = 16;
    localparam int MLO  = 31;
    localparam int MPW  = 32;
    localparam int MHI  = 33;
    localparam int MR   = 32736;
    localparam int HALF = MR / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vld_i = 1'b0;
    logic [W-1:0] din = '0;
    logic         vld_o;
    logic [N-1:0] res_lo;
    logic [N-1:0] res_pow;
    logic [N:0]   res_hi;
    logic         oor_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int e_v, e_lo, e_pow, e_hi, e_oor;
    int last_x;
    bit last_v;

    always #2.5 clk = ~clk;

    rns_fwd_conv #(.N(N), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .din(din),
        .vld_o(vld_o), .res_lo(res_lo), .res_pow(res_pow),
        .res_hi(res_hi), .oor_o(oor_o)
    );

    function automatic int rmod(input int x, input int m);
        int r;
        r = x % m;
        if (r < 0) r = r + m;
        return r;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (x=%0d)", tag, what, act, exp, last_x);
        end
    endtask

    task automatic apply(input bit v, input int x);
        string t3, t4, t5;
        bit neg, oor;
        vld_i = v;
        din   = x[W-1:0];
        @(posedge clk);
        #1;
        if (!rst_n) begin
            e_v = 0; e_lo = 0; e_pow = 0; e_hi = 0; e_oor = 0;
        end else begin
            e_v = v ? 1 : 0;
            if (v) begin
                e_lo  = rmod(x, MLO);
                e_pow = rmod(x, MPW);
                e_hi  = rmod(x, MHI);
                e_oor = (x < -HALF || x > HALF - 1) ? 1 : 0;
            end
        end
        last_x = x;
        last_v = v;
        @(negedge clk);
        neg = (x < 0);
        oor = (x < -HALF || x > HALF - 1);
        if (!rst_n) begin
            t3 = "R8"; t4 = "R8"; t5 = "R8";
        end else if (!v) begin
            t3 = "R2"; t4 = "R2"; t5 = "R2";
        end else if (oor) begin
            t3 = "R9"; t4 = "R9"; t5 = "R9";
        end else if (neg) begin
            t3 = "R6"; t4 = "R6"; t5 = "R6";
        end else begin
            t3 = "R3"; t4 = "R4"; t5 = "R5";
        end
        check(rst_n ? "R1" : "R8", "vld_o", int'(vld_o), e_v);
        check(t3, "res_pow", int'(res_pow), e_pow);
        check(t4, "res_lo", int'(res_lo), e_lo);
        check(t5, "res_hi", int'(res_hi), e_hi);
        check((rst_n && v) ? "R7" : t3, "oor_o", int'(oor_o), e_oor);
    endtask

    initial begin
        int seed;
        logic [15:0] t;
        int dir [] = '{0, 1, 2, 30, 31, 32, 33, 34, 62, 63, 64, 65, 66, 10, 1000,
                       -1, -2, -31, -32, -33, -34, -100,
                       HALF - 1, HALF, -HALF, -HALF - 1, 32767, -32768, 20000, -20000};
        @(negedge clk);
        // R8: reset state, inputs ignored while in reset
        for (int i = 0; i < 3; i++) apply(1'b1, 1234);
        rst_n = 1'b1;
        // R8: first cycle after reset with no valid word
        apply(1'b0, 77);
        // R3 R4 R5 R6 R7 R9: directed values
        foreach (dir[i]) apply(1'b1, dir[i]);
        // R2: holds across idle cycles with changing din
        apply(1'b1, 500);
        apply(1'b0, -7);
        apply(1'b0, 12345);
        // R7: walk across the lower range edge
        for (int x = -HALF - 3; x <= -HALF + 3; x++) apply(1'b1, x);
        // R4 R5: every value over several modulus periods
        for (int x = -80; x <= 80; x++) apply(1'b1, x);
        // pseudo-random sweep with valid gaps
        seed = 32'h1357;
        for (int i = 0; i < 3000; i++) begin
            seed = seed * 1103515245 + 12345;
            t = seed[30:15];
            apply((i % 4) != 3, int'($signed(t)));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule